// File: doc/BRIEF.md
# Halfword-Splitting Load/Store Unit

This unit is the memory stage of a 64-bit integer pipeline. It takes one load or store per request and carries it out over a 16-bit pipelined Wishbone master port. The request holds a size code (byte, halfword, word or doubleword), an effective address from the execute stage and, for a store, the data. Requests wider than 16 bits become a run of halfword bus beats. The most significant halfword goes first, to the lowest address, so data is placed big-endian on the bus for both loads and stores.

The command issuer and the response collector are separate pieces of logic. The issuer puts beats onto the bus as fast as STALL allows. The collector counts ACKs, packs the returned halfwords into a 64-bit result and raises a one-cycle completion pulse. While an operation is in flight a busy output holds the earlier stages.

Alignment is assumed and not checked. Load data leaves raw: right-justified and zero above the accessed width, with the size code alongside it. Extension is left to write-back.

Top module: `narrow_lsu`

## Requirements
- R1: After reset, cyc_o, stb_o, busy_o and done_o are all low.
- R2: An access makes exactly as many bus beats as its size needs. The size codes are 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. Byte and halfword take 1 beat, word takes 2 and doubleword takes 4.
- R3: Beat k (counting from 0) of an access uses the address with bit 0 cleared plus 2*k.
- R4: Store beats carry the store data most significant halfword first. For a doubleword the order is bits 63..48, 47..32, 31..16, then 15..0. A word sends bits 31..16 and then 15..0. A halfword sends bits 15..0.
- R5: A byte access drives sel_o = 2'b01 when address bit 0 is 0 and 2'b10 when it is 1. A byte store puts data bits 7..0 on both byte lanes.
- R6: Halfword, word and doubleword beats drive sel_o = 2'b11. we_o is high for every beat of a store and low for every beat of a load.
- R7: While STALL is high, a raised stb_o stays raised and adr_o keeps its value into the next cycle.
- R8: cyc_o stays high from the first beat until the ACK of the last beat has been sampled, including cycles when no strobe is pending.
- R9: A load result puts the halfwords in arrival order, with the first one most significant, right-justified in rdata_o. A byte load returns dat_i[7:0] when address bit 0 is 0 and dat_i[15:8] when it is 1. Every result bit above the accessed width is zero.
- R10: busy_o rises in the cycle after a request is accepted and stays high up to and including the cycle of the final ACK. done_o is high for exactly the one cycle after the final ACK, with rsize_o equal to the request size and busy_o low.
- R11: req_valid_i is ignored while busy_o is high. No extra beats are issued and the operation in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is low |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr_i | input | AW | Effective address |
| req_wdata_i | input | 64 | Store data, right-justified |
| busy_o | output | 1 | Operation in flight; stalls earlier stages |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 64 | Raw load result |
| rsize_o | output | 2 | Size code of the completed access |
| cyc_o | output | 1 | Bus cycle |
| stb_o | output | 1 | Bus strobe |
| we_o | output | 1 | Bus write enable |
| adr_o | output | AW | Bus byte address |
| sel_o | output | 2 | Byte-lane selects |
| dat_o | output | 16 | Write data |
| stall_i | input | 1 | Slave stall |
| ack_i | input | 1 | Slave acknowledge |
| dat_i | input | 16 | Read data |

## Verification
The case that is hardest to reach is the one where issue and response drift apart. Examples are a doubleword whose strobes have all been accepted while two or three ACKs are still owed, and a stall that lands between the middle beats. The bench slave stalls at random and keeps accepted beats in a queue, which it answers after random delays. Long waits and back-to-back ACKs therefore both occur, and the bench checks cyc_o, the strobe hold and the completion timing through those gaps. Random and directed accesses of every size and both address parities cover the lane and ordering rules.

// File: rtl/nlsu_pkg.sv
package nlsu_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } xfer_size_t;

  // number of halfword bus beats an access needs
  function automatic logic [2:0] beats_of(xfer_size_t s);
    case (s)
      SZ_W:    return 3'd2;
      SZ_D:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // halfword driven on beat k of a store, most significant first
  function automatic logic [15:0] store_half(logic [63:0] d, xfer_size_t s, logic [2:0] k);
    logic [1:0] idx;
    idx = 2'(3 - k);
    case (s)
      SZ_B:    return {d[7:0], d[7:0]};
      SZ_H:    return d[15:0];
      SZ_W:    return (k == 3'd0) ? d[31:16] : d[15:0];
      default: return d[idx*16 +: 16];
    endcase
  endfunction

  function automatic logic [1:0] sel_of(xfer_size_t s, logic a0);
    if (s == SZ_B) return a0 ? 2'b10 : 2'b01;
    return 2'b11;
  endfunction

  // fold one returned halfword into the accumulated load value
  function automatic logic [63:0] merge_beat(logic [63:0] acc, xfer_size_t s, logic a0,
                                             logic [15:0] din);
    if (s == SZ_B) return {56'd0, (a0 ? din[15:8] : din[7:0])};
    return {acc[47:0], din};
  endfunction

endpackage

// File: rtl/nlsu_cmd.sv
module nlsu_cmd
  import nlsu_pkg::*;
#(
  parameter int AW = 25,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  xfer_size_t    size,
  input  logic [AW-1:0] base,
  input  logic [63:0]   wdata,
  input  logic          stall_i,
  output logic          stb_o,
  output logic [AW-1:0] adr_o,
  output logic [15:0]   dat_o,
  output logic [1:0]    sel_o
);
  logic [CW-1:0] issued;
  logic [CW-1:0] need;
  logic          beat_taken;

  assign need       = CW'(beats_of(size));
  assign stb_o      = active && (issued < need);
  assign beat_taken = stb_o && !stall_i;
  assign adr_o      = {base[AW-1:1], 1'b0} + (AW'(issued) << 1);
  assign dat_o      = store_half(wdata, size, 3'(issued));
  assign sel_o      = sel_of(size, base[0]);

  always_ff @(posedge clk) begin
    if (!rst_n)          issued <= '0;
    else if (start)      issued <= '0;
    else if (beat_taken) issued <= issued + 1'b1;
  end

  p_stb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o && stall_i |=> stb_o && $stable(adr_o));
  p_issue_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> issued <= need);
  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o && size == SZ_B |-> $countones(sel_o) == 1);

endmodule

// File: rtl/nlsu_rsp.sv
module nlsu_rsp
  import nlsu_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        active,
  input  xfer_size_t  size,
  input  logic        a0,
  input  logic        ack_i,
  input  logic [15:0] dat_i,
  output logic        last_ack,
  output logic        done_o,
  output logic [63:0] rdata_o
);
  logic [CW-1:0] acked;
  logic [CW-1:0] need;
  logic [63:0]   acc;
  logic          took;

  assign need     = CW'(beats_of(size));
  assign took     = active && ack_i;
  assign last_ack = took && (acked == need - 1'b1);
  assign rdata_o  = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acked  <= '0;
      acc    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_ack;
      if (start) begin
        acked <= '0;
        acc   <= '0;
      end else if (took) begin
        acked <= acked + 1'b1;
        acc   <= merge_beat(acc, size, a0, dat_i);
      end
    end
  end

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_ack_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> acked < need);

endmodule

// File: rtl/narrow_lsu.sv
module narrow_lsu
  import nlsu_pkg::*;
#(
  parameter int AW   = 25,
  parameter int XLEN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [1:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [63:0]   req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [63:0]   rdata_o,
  output logic [1:0]    rsize_o,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  output logic [AW-1:0] adr_o,
  output logic [1:0]    sel_o,
  output logic [15:0]   dat_o,
  input  logic          stall_i,
  input  logic          ack_i,
  input  logic [15:0]   dat_i
);
  localparam int MAXB = XLEN / 16;
  localparam int CW   = $clog2(MAXB + 1);

  logic          active;
  logic          op_we;
  xfer_size_t    op_size;
  logic [AW-1:0] op_base;
  logic [63:0]   op_wdata;
  logic          accept;
  logic          last_ack;

  assign accept  = req_valid_i && !active;
  assign busy_o  = active;
  assign cyc_o   = active;
  assign we_o    = op_we;
  assign rsize_o = op_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      op_we    <= 1'b0;
      op_size  <= SZ_B;
      op_base  <= '0;
      op_wdata <= '0;
    end else if (accept) begin
      active   <= 1'b1;
      op_we    <= req_we_i;
      op_size  <= xfer_size_t'(req_size_i);
      op_base  <= req_addr_i;
      op_wdata <= req_wdata_i;
    end else if (last_ack) begin
      active   <= 1'b0;
    end
  end

  nlsu_cmd #(.AW(AW), .CW(CW)) cmd_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .active(active),
    .size(op_size), .base(op_base), .wdata(op_wdata), .stall_i(stall_i),
    .stb_o(stb_o), .adr_o(adr_o), .dat_o(dat_o), .sel_o(sel_o)
  );

  nlsu_rsp #(.CW(CW)) rsp_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .active(active),
    .size(op_size), .a0(op_base[0]), .ack_i(ack_i), .dat_i(dat_i),
    .last_ack(last_ack), .done_o(done_o), .rdata_o(rdata_o)
  );

  p_cyc_until_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o && !last_ack |=> cyc_o);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_req_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !last_ack |=> $stable(op_base) && $stable(op_size) && $stable(op_we));
  p_stb_in_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> cyc_o);

endmodule

// File: tb/narrow_lsu_tb_top.sv
module narrow_lsu_tb_top;
  localparam int AW = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [1:0]    req_size_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [63:0]   req_wdata_i = '0;
  logic          busy_o, done_o, cyc_o, stb_o, we_o;
  logic [63:0]   rdata_o;
  logic [1:0]    rsize_o, sel_o;
  logic [AW-1:0] adr_o;
  logic [15:0]   dat_o;
  logic          stall_i = 1'b0, ack_i = 1'b0;
  logic [15:0]   dat_i = '0;

  always #2.5 clk = ~clk;

  narrow_lsu #(.AW(AW)) dut_i (.*);

  int errors = 0, checks = 0, cyc_cnt = 0;
  int hold_err = 0, cyc_err = 0, last_ack_edge = 0, stall_pct = 25;
  logic [AW-1:0] log_adr[$];
  logic [15:0]   log_dat[$];
  logic [1:0]    log_sel[$];
  logic          log_we[$];
  logic [15:0]   pq[$];
  logic          prev_hold = 1'b0;
  logic [AW-1:0] prev_adr = '0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [15:0] pat(logic [AW-1:0] a);
    return 16'(a * 16'h9e37) ^ 16'h5a5a;
  endfunction

  function automatic int nbeats(logic [1:0] s);
    return (s == 2'd3) ? 4 : (s == 2'd2) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave: random stall, queued responses with random delay
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (prev_hold && !(stb_o && adr_o == prev_adr)) hold_err++;
      if (pq.size() > 0 && !cyc_o) cyc_err++;
      if (pq.size() > 0 && ($urandom % 3) != 0) begin
        ack_i = 1'b1;
        dat_i = pq.pop_front();
        last_ack_edge = cyc_cnt + 1;
      end else begin
        ack_i = 1'b0;
        dat_i = 16'($urandom);
      end
      stall_i = int'($urandom % 100) < stall_pct;
      if (stb_o && !stall_i) begin
        log_adr.push_back(adr_o);
        log_dat.push_back(dat_o);
        log_sel.push_back(sel_o);
        log_we.push_back(we_o);
        pq.push_back(pat(adr_o));
      end
      prev_hold = stb_o && stall_i;
      prev_adr  = adr_o;
    end
  end

  task automatic do_op(input logic we, input logic [1:0] sz, input logic [AW-1:0] addr,
                       input logic [63:0] wd);
    int n, guard;
    logic [63:0] exp_rd;
    logic [AW-1:0] b;
    logic [15:0] eh;
    n = nbeats(sz);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    log_adr.delete(); log_dat.delete(); log_sel.delete(); log_we.delete();
    req_valid_i = 1'b1; req_we_i = we; req_size_i = sz;
    req_addr_i = addr; req_wdata_i = wd;
    @(negedge clk);
    chk(busy_o === 1'b1, "R10 busy after accept", 64'(busy_o), 64'd1);
    // bogus request held while busy: must be ignored (R11)
    req_we_i = ~we; req_size_i = 2'd3; req_addr_i = addr ^ 25'h155550;
    req_wdata_i = ~wd;
    guard = 0;
    while (!done_o && guard < 2000) begin
      @(negedge clk);
      if (!busy_o) req_valid_i = 1'b0;
      guard++;
    end
    req_valid_i = 1'b0;
    chk(done_o === 1'b1, "R10 done seen", 64'(done_o), 64'd1);
    chk(cyc_cnt == last_ack_edge, "R10 done one cycle after final ack",
        64'(cyc_cnt), 64'(last_ack_edge));
    chk(busy_o === 1'b0 && rsize_o === sz, "R10 busy low and rsize at done",
        {62'd0, rsize_o}, {62'd0, sz});
    chk(log_adr.size() == n, "R2 R11 beat count", 64'(log_adr.size()), 64'(n));
    b = {addr[AW-1:1], 1'b0};
    exp_rd = '0;
    for (int k = 0; k < n && k < log_adr.size(); k++) begin
      chk(log_adr[k] === b + AW'(2 * k), "R3 beat address", 64'(log_adr[k]), 64'(b + AW'(2 * k)));
      chk(log_sel[k] === ((sz == 2'd0) ? (addr[0] ? 2'b10 : 2'b01) : 2'b11), "R5 R6 sel",
          64'(log_sel[k]), 64'((sz == 2'd0) ? (addr[0] ? 2'b10 : 2'b01) : 2'b11));
      chk(log_we[k] === we, "R6 we", 64'(log_we[k]), 64'(we));
      if (we) begin
        eh = (sz == 2'd0) ? {wd[7:0], wd[7:0]} : wd[16*(n-1-k) +: 16];
        chk(log_dat[k] === eh, "R4 R5 store halfword", 64'(log_dat[k]), 64'(eh));
      end
      if (sz == 2'd0) exp_rd = {56'd0, addr[0] ? pat(log_adr[k])[15:8] : pat(log_adr[k])[7:0]};
      else exp_rd = {exp_rd[47:0], pat(b + AW'(2 * k))};
    end
    if (!we) chk(rdata_o === exp_rd, "R9 load result", rdata_o, exp_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({cyc_o, stb_o, busy_o, done_o} === 4'b0, "R1 reset outputs",
        64'({cyc_o, stb_o, busy_o, done_o}), 64'd0);
    rst_n = 1'b1;
    // directed corner cases
    stall_pct = 0;
    do_op(1'b1, 2'd3, 25'h000100, 64'h1122334455667788);
    do_op(1'b0, 2'd3, 25'h000200, 64'd0);
    do_op(1'b1, 2'd0, 25'h000301, 64'h00000000000000a5);
    do_op(1'b1, 2'd0, 25'h000302, 64'h000000000000003c);
    do_op(1'b0, 2'd0, 25'h000303, 64'd0);
    do_op(1'b0, 2'd0, 25'h000304, 64'd0);
    stall_pct = 80;
    do_op(1'b1, 2'd2, 25'h000404, 64'hdeadbeefcafef00d);
    do_op(1'b0, 2'd2, 25'h000408, 64'd0);
    do_op(1'b0, 2'd1, 25'h00040a, 64'd0);
    do_op(1'b1, 2'd3, 25'h1ffff8, 64'h0123456789abcdef);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      logic [AW-1:0] a;
      sz = 2'($urandom % 4);
      a = AW'($urandom);
      a = a & ~AW'((1 << sz) - 1);
      stall_pct = (i % 50 < 10) ? 70 : 20;
      do_op(1'($urandom), sz, a, {$urandom, $urandom});
    end
    repeat (5) @(negedge clk);
    chk(hold_err == 0, "R7 stall holds strobe and address", 64'(hold_err), 64'd0);
    chk(cyc_err == 0, "R8 cyc held while acks owed", 64'(cyc_err), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule